// File: doc/BRIEF.md
# External Interrupt Flag Aggregator

This block gathers interrupt requests from outside an 8051-style CPU core and keeps them as latched flags in one request register. Two dedicated pins feed request inputs 2 and 3. Software chooses the active edge of each pin. Three merged lines feed request inputs 4, 5 and 6. Each merged line combines three peripheral event sources.

Every peripheral source has its own pending flag and its own mask bit. A line's combined level is the OR of its pending flags that are unmasked. The block turns a low-to-high change of that level into a single set event for the matching request bit. Reading a line register clears the pending flags of that line. When the CPU acknowledges a request, the request bit clears.

Software uses a byte-wide register bus for all of this. The CPU sees a request only when its enable bit is also set.

The bus decodes these addresses:

| Address | Register | Contents |
|---|---|---|
| 0xC0 | request | request flags |
| 0xC1 | enable | enable bits |
| 0xC2 | edge control | one edge-select bit per pin |
| 0xC4 to 0xC6 | line registers | one register per merged line |

Each pin runs a small state machine over its synchronized level. The two states are PIN_LOW and PIN_HIGH:
- PIN_LOW goes to PIN_HIGH when the synchronized level is 1. This transition reports a rise.
- PIN_HIGH goes to PIN_LOW when the synchronized level is 0. This transition reports a fall.
- In all other cases the state holds.

Each merged line runs a state machine over its combined level. The two states are LN_QUIET and LN_ACTIVE:
- LN_QUIET goes to LN_ACTIVE when the combined level is 1. This transition issues the set event.
- LN_ACTIVE goes back to LN_QUIET when the combined level is 0.
- In all other cases the state holds.

Top module: `irq_flag_hub`

## Requirements
- R1: After reset, every register (0xC0, 0xC1, 0xC2, 0xC4, 0xC5, 0xC6) reads 0x00 and `irq_req` is 0.
- R2: In the request register at 0xC0, bits 1 to 5 hold the flags of interrupts 2 to 6 in ascending order. Bits 0, 6 and 7 always read 0, even after a write of 0xFF.
- R3: Edge-control bit 0 applies to `pin_in[0]` (interrupt 2) and bit 1 applies to `pin_in[1]` (interrupt 3). A value of 0 selects the rising edge and 1 selects the falling edge. The selected edge sets the request flag three clock edges after the pin changes: two synchronizer stages plus one cycle. The other edge has no effect.
- R4: Bit j of `src_ev` slice k sets pending flag j of line k whatever the mask. Slice k is bits 3k+2 to 3k. Line k is register 0xC4+k and feeds interrupt 4+k. A line register holds the pending flags in bits 2:0 and the mask bits in bits 6:4.
- R5: The combined level of a line is the OR of its pending flags that are unmasked. A 0-to-1 change of that level sets the request flag one cycle after the level rises. A level that stays high does not set the flag again. Unmasking a flag that is already pending raises the level and sets the flag.
- R6: A read of a line register returns its current value and clears all pending flags of that line. The mask bits are kept. A write to a line register changes only the mask bits.
- R7: If a source event arrives in the same cycle as a clearing read of its line, that flag stays set afterwards.
- R8: A one-cycle pulse on `irq_ack[k]` clears request flag k. If a set event for the same flag arrives in that cycle, the set wins and the flag stays set.
- R9: A write to 0xC0 loads request bits 5:1 directly. If an acknowledge arrives in the same cycle as the write, the acknowledge clears that bit.
- R10: `irq_req[k]` equals request flag k ANDed with enable bit k+1 of register 0xC1.
- R11: `bus_rdata` is 0 while `bus_rd` is low, and 0 on a read of an address that is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of a line register clears its pending flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 2 | Asynchronous dedicated interrupt pins for interrupts 2 and 3 |
| src_ev | input | 9 | Peripheral event pulses, three per merged line |
| irq_ack | input | 5 | CPU acknowledge, bit k for interrupt k+2 |
| irq_req | output | 5 | Enabled requests to the CPU, bit k for interrupt k+2 |

## Verification
The bound checker tests these rules on every cycle:
- Reserved request bits always read 0.
- A clearing read empties the pending flags that received no event in that cycle.
- An event that coincides with a read keeps its flag.
- An acknowledge clears its request bit unless a set event arrives in the same cycle.
- A set event always lands in the request register.
- No request leaves the block while its enable bit is 0.

Only the bench scenarios can show the following:
- The three-edge latency of the pins and the effect of each edge-select bit.
- That a line which stays high does not set its request again.
- That unmasking a pending flag raises a request.
- That software writes to the request register and an acknowledge in the same cycle resolve as the requirements state.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_t;

    typedef enum logic {
        LN_QUIET  = 1'b0,
        LN_ACTIVE = 1'b1
    } line_state_t;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_t;

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
    import irq_hub_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic fall_sel,
    output logic edge_ev
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    pin_state_t             state_q;
    pin_state_t             state_d;
    logic                   rise_seen;
    logic                   fall_seen;

    // Synchronizer chain; the last stage feeds the edge state machine.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (pin_s)  state_d = PIN_HIGH;
            PIN_HIGH: if (!pin_s) state_d = PIN_LOW;
        endcase
    end

    // Outputs: an edge is reported on the cycle in which the state changes.
    always_comb begin
        rise_seen = 1'b0;
        fall_seen = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise_seen = pin_s;
            PIN_HIGH: fall_seen = !pin_s;
        endcase
        edge_ev = (edge_sel_t'(fall_sel) == EDGE_FALL) ? fall_seen : rise_seen;
    end

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
    import irq_hub_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_ev,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] mask_wdata,
    input  logic            clr_rd,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] masks,
    output logic            rise_ev
);

    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] mask_q;
    logic            level;
    line_state_t     state_q;
    line_state_t     state_d;

    // Pending flags: a clearing read empties them, and a new event always wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~{NSRC{clr_rd}}) | src_ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    assign level = |(flag_q & mask_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_QUIET:  if (level)  state_d = LN_ACTIVE;
            LN_ACTIVE: if (!level) state_d = LN_QUIET;
        endcase
    end

    // Output: the set event is issued on the transition from quiet to active.
    always_comb begin
        rise_ev = 1'b0;
        unique case (state_q)
            LN_QUIET:  rise_ev = level;
            LN_ACTIVE: rise_ev = 1'b0;
        endcase
    end

    assign flags = flag_q;
    assign masks = mask_q;

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int NREQ = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_ev,
    input  logic [NREQ-1:0] ack,
    input  logic            req_wr,
    input  logic [NREQ-1:0] req_wdata,
    input  logic            ena_wr,
    input  logic [NREQ-1:0] ena_wdata,
    output logic [NREQ-1:0] req_q,
    output logic [NREQ-1:0] ena_q,
    output logic [NREQ-1:0] irq_out
);

    // Per-bit priority: hardware set, then acknowledge, then software write.
    for (genvar k = 0; k < NREQ; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[k] <= 1'b0;
            end else if (set_ev[k]) begin
                req_q[k] <= 1'b1;
            end else if (ack[k]) begin
                req_q[k] <= 1'b0;
            end else if (req_wr) begin
                req_q[k] <= req_wdata[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (ena_wr) begin
            ena_q <= ena_wdata;
        end
    end

    assign irq_out = req_q & ena_q;

endmodule

// File: rtl/irq_flag_hub.sv
module irq_flag_hub
    import irq_hub_pkg::*;
#(
    parameter int               ADDR_W       = 8,
    parameter int               DATA_W       = 8,
    parameter int               NUM_PINS     = 2,
    parameter int               NUM_LINES    = 3,
    parameter int               SRC_PER_LINE = 3,
    parameter int               SYNC_STAGES  = 2,
    parameter logic [ADDR_W-1:0] ADDR_REQ    = 8'hC0,
    parameter logic [ADDR_W-1:0] ADDR_ENA    = 8'hC1,
    parameter logic [ADDR_W-1:0] ADDR_CTL    = 8'hC2,
    parameter logic [ADDR_W-1:0] ADDR_LINE0  = 8'hC4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]               pin_in,
    input  logic [NUM_LINES*SRC_PER_LINE-1:0] src_ev,
    input  logic [NUM_PINS+NUM_LINES-1:0]     irq_ack,
    output logic [NUM_PINS+NUM_LINES-1:0]     irq_req
);

    localparam int NUM_REQ  = NUM_PINS + NUM_LINES;
    localparam int REQ_LSB  = 1;
    localparam int MASK_LSB = DATA_W / 2;
    localparam int NSRC_ALL = NUM_LINES * SRC_PER_LINE;

    logic                hit_req;
    logic                hit_ena;
    logic                hit_ctl;
    logic [NUM_PINS-1:0] ctl_q;
    logic [NUM_REQ-1:0]  set_ev;
    logic [NUM_REQ-1:0]  req_q;
    logic [NUM_REQ-1:0]  ena_q;
    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_LINES-1:0] line_clr;
    logic [NSRC_ALL-1:0]  line_flags;
    logic [NSRC_ALL-1:0]  line_masks;

    assign hit_req = (bus_addr == ADDR_REQ);
    assign hit_ena = (bus_addr == ADDR_ENA);
    assign hit_ctl = (bus_addr == ADDR_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (bus_wr && hit_ctl) begin
            ctl_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_pin_edge #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_in[p]),
            .fall_sel  (ctl_q[p]),
            .edge_ev   (set_ev[p])
        );
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam logic [ADDR_W-1:0] LINE_ADDR = ADDR_LINE0 + ADDR_W'(l);

        assign line_hit[l] = (bus_addr == LINE_ADDR);
        assign line_clr[l] = bus_rd && line_hit[l];

        irq_line_merge #(
            .NSRC (SRC_PER_LINE)
        ) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_ev     (src_ev[l*SRC_PER_LINE +: SRC_PER_LINE]),
            .mask_wr    (bus_wr && line_hit[l]),
            .mask_wdata (bus_wdata[MASK_LSB +: SRC_PER_LINE]),
            .clr_rd     (line_clr[l]),
            .flags      (line_flags[l*SRC_PER_LINE +: SRC_PER_LINE]),
            .masks      (line_masks[l*SRC_PER_LINE +: SRC_PER_LINE]),
            .rise_ev    (set_ev[NUM_PINS + l])
        );
    end

    irq_req_bank #(
        .NREQ (NUM_REQ)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (set_ev),
        .ack       (irq_ack),
        .req_wr    (bus_wr && hit_req),
        .req_wdata (bus_wdata[REQ_LSB +: NUM_REQ]),
        .ena_wr    (bus_wr && hit_ena),
        .ena_wdata (bus_wdata[REQ_LSB +: NUM_REQ]),
        .req_q     (req_q),
        .ena_q     (ena_q),
        .irq_out   (irq_req)
    );

    // Read path: zero when idle or unmapped.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_req) begin
                bus_rdata[REQ_LSB +: NUM_REQ] = req_q;
            end else if (hit_ena) begin
                bus_rdata[REQ_LSB +: NUM_REQ] = ena_q;
            end else if (hit_ctl) begin
                bus_rdata[NUM_PINS-1:0] = ctl_q;
            end else begin
                for (int l = 0; l < NUM_LINES; l++) begin
                    if (line_hit[l]) begin
                        bus_rdata[0 +: SRC_PER_LINE] =
                            line_flags[l*SRC_PER_LINE +: SRC_PER_LINE];
                        bus_rdata[MASK_LSB +: SRC_PER_LINE] =
                            line_masks[l*SRC_PER_LINE +: SRC_PER_LINE];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_flag_hub_chk.sv
module irq_flag_hub_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_REQ   = 5,
    parameter int NUM_LINES = 3,
    parameter int NSRC      = 3,
    parameter logic [ADDR_W-1:0] ADDR_REQ = 8'hC0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_rd,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_rdata,
    input logic [NUM_REQ-1:0]          irq_ack,
    input logic [NUM_REQ-1:0]          irq_req,
    input logic [NUM_REQ-1:0]          set_ev,
    input logic [NUM_REQ-1:0]          req_q,
    input logic [NUM_REQ-1:0]          ena_q,
    input logic [NUM_LINES*NSRC-1:0]   src_ev,
    input logic [NUM_LINES-1:0]        line_clr,
    input logic [NUM_LINES*NSRC-1:0]   line_flags
);

    localparam logic [DATA_W-1:0] REQ_FIELD = DATA_W'(((1 << NUM_REQ) - 1) << 1);

    logic [NUM_LINES*NSRC-1:0] clr_bits;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_clr
        assign clr_bits[l*NSRC +: NSRC] = {NSRC{line_clr[l]}};
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_REQ) |-> ((bus_rdata & ~REQ_FIELD) == '0));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((line_flags & $past(clr_bits & ~src_ev)) == '0));

    // R7
    event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((line_flags & $past(src_ev)) == $past(src_ev)));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & $past(irq_ack & ~set_ev)) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & $past(set_ev)) == $past(set_ev)));

    // R10
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~ena_q) == '0));

endmodule

bind irq_flag_hub irq_flag_hub_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_REQ   (NUM_PINS + NUM_LINES),
    .NUM_LINES (NUM_LINES),
    .NSRC      (SRC_PER_LINE),
    .ADDR_REQ  (ADDR_REQ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .set_ev     (set_ev),
    .req_q      (req_q),
    .ena_q      (ena_q),
    .src_ev     (src_ev),
    .line_clr   (line_clr),
    .line_flags (line_flags)
);

// File: tb/tb_irq_flag_hub.sv
module tb_irq_flag_hub;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = '0;
    logic [8:0] src_ev = '0;
    logic [4:0] irq_ack = '0;
    logic [4:0] irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    irq_flag_hub dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .src_ev    (src_ev),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        tick();
        bus_rd   = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [4:0] exp_req;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state of every register and of irq_req
        foreach (d[i]) begin end
        rd(8'hC0, d); chk("R1 req reg", d, 0);
        rd(8'hC1, d); chk("R1 ena reg", d, 0);
        rd(8'hC2, d); chk("R1 ctl reg", d, 0);
        for (int l = 0; l < 3; l++) begin
            rd(8'hC4 + 8'(l), d); chk("R1 line reg", d, 0);
        end
        chk("R1 irq_req", irq_req, 0);

        // R11: idle and unmapped reads return zero
        chk("R11 idle rdata", bus_rdata, 0);
        rd(8'hC3, d); chk("R11 unmapped C3", d, 0);
        rd(8'h00, d); chk("R11 unmapped 00", d, 0);

        // R2: reserved bits of the request register
        wr(8'hC0, 8'hFF);
        rd(8'hC0, d); chk("R2 reserved bits zero", d, 8'h3E);

        // R9/R10: sweep request and enable patterns
        for (int e = 0; e < 4; e++) begin
            logic [4:0] ev;
            ev = (e == 0) ? 5'h1F : (e == 1) ? 5'h0A : (e == 2) ? 5'h15 : 5'h00;
            wr(8'hC1, {2'b00, ev, 1'b0});
            for (int v = 0; v < 32; v++) begin
                wr(8'hC0, {2'b00, 5'(v), 1'b0});
                chk("R10 irq_req gate", irq_req, 5'(v) & ev);
            end
        end
        wr(8'hC1, 8'h3E);
        rd(8'hC0, d); chk("R9 write load", d, 8'h3E);

        // R9: acknowledge beats a software write in the same cycle
        bus_addr = 8'hC0; bus_wdata = 8'h3E; bus_wr = 1'b1; irq_ack = 5'b00100;
        tick();
        bus_wr = 1'b0; irq_ack = '0;
        rd(8'hC0, d); chk("R9 ack beats write", d, 8'h36);

        // R8: acknowledge clears each bit on its own
        for (int k = 0; k < 5; k++) begin
            wr(8'hC0, 8'h3E);
            irq_ack = 5'(1 << k);
            tick();
            irq_ack = '0;
            chk("R8 ack clears", irq_req, 5'h1F & ~5'(1 << k));
        end

        // R3: pin edge sweep over pin and polarity
        for (int p = 0; p < 2; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                wr(8'hC2, 8'(pol << p));
                wr(8'hC0, 8'h00);
                pin_in[p] = 1'b1;
                tick(); tick();
                chk("R3 rise not yet", irq_req, 0);
                tick();
                chk("R3 rising edge", irq_req, (pol == 0) ? 5'(1 << p) : 5'h0);
                repeat (2) tick();
                wr(8'hC0, 8'h00);
                pin_in[p] = 1'b0;
                tick(); tick();
                chk("R3 fall not yet", irq_req, 0);
                tick();
                chk("R3 falling edge", irq_req, (pol == 1) ? 5'(1 << p) : 5'h0);
                repeat (2) tick();
            end
        end
        wr(8'hC2, 8'h00);

        // R4/R5/R6: line, mask and source sweep
        for (int l = 0; l < 3; l++) begin
            for (int m = 0; m < 8; m++) begin
                for (int s = 0; s < 3; s++) begin
                    rd(8'hC4 + 8'(l), d);
                    wr(8'hC4 + 8'(l), 8'(m << 4) | 8'h07);
                    tick();
                    wr(8'hC0, 8'h00);
                    src_ev = 9'(1 << (l * 3 + s));
                    tick();
                    src_ev = '0;
                    tick();
                    exp_req = ((m >> s) & 1) != 0 ? 5'(1 << (2 + l)) : 5'h0;
                    chk("R5 line request", irq_req, exp_req);
                    rd(8'hC4 + 8'(l), d);
                    chk("R4 flag regardless of mask", d, 8'(m << 4) | 8'(1 << s));
                    rd(8'hC4 + 8'(l), d);
                    chk("R6 read cleared flags", d, 8'(m << 4));
                end
            end
        end

        // R5: level that stays high does not set again
        wr(8'hC4, 8'h10);
        tick();
        wr(8'hC0, 8'h00);
        src_ev = 9'h001; tick(); src_ev = '0; tick();
        chk("R5 first rise", irq_req, 5'b00100);
        irq_ack = 5'b00100; tick(); irq_ack = '0;
        src_ev = 9'h001; tick(); src_ev = '0; tick(); tick();
        chk("R5 no retrigger", irq_req, 0);

        // R5: unmasking a pending flag raises a request
        rd(8'hC4, d);
        wr(8'hC4, 8'h00);
        tick();
        src_ev = 9'h002; tick(); src_ev = '0; tick();
        chk("R5 masked no request", irq_req, 0);
        wr(8'hC4, 8'h20);
        tick();
        chk("R5 unmask raises", irq_req, 5'b00100);
        rd(8'hC4, d);
        wr(8'hC0, 8'h00);

        // R7: event during a clearing read survives
        wr(8'hC5, 8'h00);
        src_ev = 9'h008; tick(); src_ev = '0;
        bus_addr = 8'hC5; bus_rd = 1'b1; src_ev = 9'h020;
        #1;
        chk("R7 read returns old flags", bus_rdata, 8'h01);
        tick();
        bus_rd = 1'b0; src_ev = '0;
        rd(8'hC5, d); chk("R7 coincident event kept", d, 8'h04);

        // R8: set event beats acknowledge in the same cycle
        wr(8'hC6, 8'h10);
        wr(8'hC0, 8'h00);
        src_ev = 9'h040; tick(); src_ev = '0;
        irq_ack = 5'b10000;
        tick();
        irq_ack = '0;
        chk("R8 set beats ack", irq_req, 5'b10000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule